// File: doc/BRIEF.md
# Serial Command Frame Shifter with Readback

This block is the receive and transmit front end of a serial slave that runs entirely in the system clock domain. The serial clock, the active-low select and the serial data line each pass through a synchronizer. Serial-clock and select edges are then detected from the synchronized levels. While select is low, every rising serial-clock edge shifts one data bit into a 16-bit shift register, most significant bit first. When select rises, whatever the shift register holds is handed to a register block as one command. The command is presented for a single system cycle on a parallel strobe.

A command carries three fields: a read flag, a 7-bit register address and a data byte. If the read flag is set, the register block returns a byte in the same cycle as the strobe. That byte replaces the low half of the shift register. During the next frame it leaves on the serial output as the second byte. The serial output changes only on falling serial-clock edges, and it presents the top bit of the shift register as soon as select falls. As a result, a bit entering the data input reappears on the output 15.5 serial-clock periods later, so several of these slaves can be chained output-to-input. The output is always driven.

Top module: `spi_frame_shifter`

## Requirements
- R1: On each rising edge of select, exactly one `cmd_valid_o` pulse, one system cycle wide, is produced. During the pulse, `cmd_read_o`, `cmd_addr_o` and `cmd_data_o` carry shift-register bit 15, bits 14..8 and bits 7..0 respectively. No pulse occurs at any other time.
- R2: While select is low, each rising serial-clock edge shifts the shift register left by one and places the data-input level in bit 0. The first bit sent therefore ends up in bit 15 after 16 clocks.
- R3: While select is high, serial-clock and data-input activity changes neither the shift register nor `dout_o`, and it produces no command strobe.
- R4: A frame with fewer or more than 16 clocks commits the most recent 16 bits shifted in. When fewer than 16 were sent, those bits include bits left over from the previous frame.
- R5: When the strobe carries the read flag (bit 15 = 1), `rd_data_i` is sampled in the strobe cycle and written into shift-register bits 7..0. On `dout_o` of the next frame, those eight bits appear as bits 9 to 16 of the stream, which is the second byte.
- R6: A write command (bit 15 = 0) leaves the shift register unchanged at commit. The next frame therefore streams the written 16 bits back out on `dout_o`.
- R7: On the falling edge of select, `dout_o` takes shift-register bit 15. After that it changes only on falling serial-clock edges while select is low, each time taking the current bit 15. A bit presented at the data input before rising edge k reappears on `dout_o` before rising edge k+16.
- R8: `dout_o` holds its value for as long as select stays high.
- R9: Synchronous reset clears the shift register to zero, drives `dout_o` low and removes any strobe.
- R10: The pins are synchronized through two flops, so `cmd_valid_o` rises on the third system clock edge after the select pin rises. The system clock must run at least four times as fast as the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| cs_n_i | input | 1 | Active-low select pin, asynchronous |
| din_i | input | 1 | Serial data input pin, asynchronous |
| dout_o | output | 1 | Serial data output, always driven |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_read_o | output | 1 | Read flag of the committed command |
| cmd_addr_o | output | 7 | Register address of the committed command |
| cmd_data_o | output | 8 | Data byte of the committed command |
| rd_data_i | input | 8 | Register contents returned for a read, sampled during the strobe |

## Verification
Any corruption of the shift register shows up on the ports in two places: in the fields of the next strobe, and in the output stream of the following frame. The output stream is compared bit by bit before every rising serial-clock edge, so a single wrong bit is reported within one serial-clock period of being shifted out. A lost or doubled edge detection changes the number of shifts, which moves every later bit of the stream and corrupts the next command. A faulty readback load shows up only in bits 9 to 16 of the frame after a read. Any strobe that is missing, extra or two cycles long is caught on the same clock it occurs.

// File: rtl/spi_fs_pkg.sv
package spi_fs_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = FRAME_W - DATA_W - 1;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/spi_fs_sync.sv
module spi_fs_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= async_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign level_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_fs_edge.sv
module spi_fs_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= level_i;
  end

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_edge
      assign rise_o[g] =  level_i[g] & ~prev[g];
      assign fall_o[g] = ~level_i[g] &  prev[g];
    end
  endgenerate
endmodule

// File: rtl/spi_fs_shifter.sv
module spi_fs_shifter #(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_low,
  input  logic               shift_en,
  input  logic               out_en,
  input  logic               sel_fall,
  input  logic               din,
  input  logic               load_en,
  input  logic [DATA_W-1:0]  load_data,
  output logic [FRAME_W-1:0] sr_o,
  output logic               dout_o
);
  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)                       sr <= '0;
    else if (load_en)              sr[DATA_W-1:0] <= load_data;
    else if (shift_en && sel_low)  sr <= {sr[FRAME_W-2:0], din};
  end

  always_ff @(posedge clk) begin
    if (rst)                                 dout_o <= 1'b0;
    else if (sel_fall || (out_en && sel_low)) dout_o <= sr[FRAME_W-1];
  end

  assign sr_o = sr;

  a_r2_shift_msb_first: assert property (@(posedge clk) disable iff (rst)
    (shift_en && sel_low && !load_en) |=>
      (sr == {$past(sr[FRAME_W-2:0]), $past(din)}));

  a_r3_hold_while_idle: assert property (@(posedge clk) disable iff (rst)
    (!sel_low && !load_en) |=> $stable(sr));

  a_r5_readback_load: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (sr[DATA_W-1:0] == $past(load_data)));

  a_r8_dout_hold: assert property (@(posedge clk) disable iff (rst)
    !sel_low |=> $stable(dout_o));
endmodule

// File: rtl/spi_fs_commit.sv
module spi_fs_commit
  import spi_fs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sel_rise,
  input  frame_t frame_i,
  output logic   valid_o,
  output frame_t frame_o,
  output logic   load_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      frame_o <= '0;
    end else begin
      valid_o <= sel_rise;
      if (sel_rise) frame_o <= frame_i;
    end
  end

  assign load_o = valid_o & frame_o.rd;

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r1_only_on_select_rise: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(sel_rise));

  a_r6_no_load_on_write: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !frame_o.rd) |-> !load_o);
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_fs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              cmd_valid_o,
  output logic              cmd_read_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  logic [2:0]         pins_s;
  logic               din_s, cs_s, sclk_s;
  logic [1:0]         rise, fall;
  logic [FRAME_W-1:0] sr;
  logic               load_en;
  frame_t             cmd;

  spi_fs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk(clk), .rst(rst), .async_i({din_i, cs_n_i, sclk_i}), .level_o(pins_s));

  assign {din_s, cs_s, sclk_s} = pins_s;

  // bit 1 = select, bit 0 = serial clock
  spi_fs_edge #(.W(2), .RST_VAL(2'b10)) i_edge (
    .clk(clk), .rst(rst), .level_i({cs_s, sclk_s}), .rise_o(rise), .fall_o(fall));

  spi_fs_shifter #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst(rst), .sel_low(!cs_s), .shift_en(rise[0]), .out_en(fall[0]),
    .sel_fall(fall[1]), .din(din_s), .load_en(load_en), .load_data(rd_data_i),
    .sr_o(sr), .dout_o(dout_o));

  spi_fs_commit i_commit (
    .clk(clk), .rst(rst), .sel_rise(rise[1]), .frame_i(frame_t'(sr)),
    .valid_o(cmd_valid_o), .frame_o(cmd), .load_o(load_en));

  assign cmd_read_o = cmd.rd;
  assign cmd_addr_o = cmd.addr;
  assign cmd_data_o = cmd.data;

  a_r7_dout_edges_only: assert property (@(posedge clk) disable iff (rst)
    (dout_o != $past(dout_o)) |-> ($past(fall[1]) || ($past(fall[0]) && !$past(cs_s))));

  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!cmd_valid_o && !dout_o));
endmodule

// File: tb/test_spi_frame_shifter.sv
module test_spi_frame_shifter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic       dout, cmd_valid, cmd_read;
  logic [6:0] cmd_addr;
  logic [7:0] cmd_data, rd_data;

  int errors = 0, checks = 0;
  logic [15:0] msr = '0;
  logic        outq[$];
  logic [15:0] expq[$];
  logic        prev_valid = 1'b0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] regval(input logic [6:0] a);
    return {a, 1'b1} ^ 8'hA5;
  endfunction

  assign rd_data = regval(cmd_addr);

  spi_frame_shifter i_spi_frame_shifter (
    .clk(clk), .rst(rst), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
    .dout_o(dout), .cmd_valid_o(cmd_valid), .cmd_read_o(cmd_read),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .rd_data_i(rd_data));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // per-clock monitor of the command strobe (R1)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (cmd_valid) begin
        chk("R1 strobe width", {31'd0, prev_valid}, 32'd0);
        if (expq.size() == 0) chk("R1 unexpected strobe", 32'd1, 32'd0);
        else begin
          logic [15:0] e;
          e = expq.pop_front();
          chk("R1 command fields", {16'd0, cmd_read, cmd_addr, cmd_data}, {16'd0, e});
        end
      end
      prev_valid <= cmd_valid;
    end
  end

  task automatic xfer(input int n, input logic [31:0] bits, input string tag);
    outq.delete();
    for (int i = 15; i >= 0; i--) outq.push_back(msr[i]);
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic b;
      chk(tag, {31'd0, dout}, {31'd0, outq[k]});
      b = bits[n-1-k];
      din = b;
      @(negedge clk); sclk = 1'b1;
      msr = {msr[14:0], b};
      outq.push_back(b);
      repeat (4) @(negedge clk); sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    cs_n = 1'b1;
    expq.push_back(msr);
    if (msr[15]) msr[7:0] = regval(msr[14:8]);
    repeat (3) @(negedge clk);
    chk("R10 strobe latency", {31'd0, cmd_valid}, 32'd1);
    repeat (6) @(negedge clk);
    chk("R1 strobe count", expq.size(), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic held;
    repeat (4) @(negedge clk);
    chk("R9 dout after reset", {31'd0, dout}, 32'd0);
    chk("R9 no strobe in reset", {31'd0, cmd_valid}, 32'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 dout idle", {31'd0, dout}, 32'd0);

    xfer(16, 32'h0355, "R9 zero stream after reset");
    xfer(16, 32'h7FAA, "R2 stream");

    // activity with select high must be ignored
    held = dout;
    for (int i = 0; i < 20; i++) begin
      din = i[0]; @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
      repeat (4) @(negedge clk);
      chk("R8 dout held while select high", {31'd0, dout}, {31'd0, held});
    end
    chk("R3 no strobe while idle", expq.size(), 32'd0);
    xfer(16, 32'h1234, "R3 state unchanged by idle clocks");
    xfer(16, 32'h2000, "R6 write data streamed back");

    xfer(16, 32'h8A00, "R7 stream delay");
    xfer(16, 32'h20E7, "R5 readback second byte");
    xfer(8,  32'h00C3, "R7 stream");          // commits E7C3: a read of 0x67
    xfer(16, 32'h2011, "R4 short frame readback");
    xfer(24, 32'hABCD12, "R4 long frame stream");
    xfer(16, 32'h0000, "R4 long frame kept last bits");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule